// File: doc/BRIEF.md
# Spread-Spectrum Modulation Profile Controller

This block is the digital steering logic for a spread-spectrum clock synthesizer. Running on the reference clock, it sweeps a signed frequency-offset code along a slow triangular profile. A downstream synthesizer adds this code to its nominal frequency. The sweep spreads clock energy over a narrow band and lowers the peak emission of the clock and of everything timed by it. The analog loop, the oscillator and the clock buffers are outside this block. It produces only control codes.

An active-low input switches the sweep on. A width select picks a narrow or a wide total spread. A mode strap places the band either wholly below nominal (down spread) or around it (center spread). A restart input returns the sweep to its starting point. Two enable pins are decoded into gating controls for a group of five clock outputs and a separate sixth output. A flag marks the unmodulated reference copy as always active.

Top module: `ssc_profile_ctrl`

## Requirements
- R1: `offset_code` is signed, in units of 0.005% (half of 0.01%). `wide_sel`=0 gives a total span of 250 codes (1.25%) and `wide_sel`=1 gives 750 codes (3.75%).
- R2: For profile phase p (0..1023), let t = p when p < 512, else 1023-p. The code is then top - floor(span*t/511). Here top = 0 in down mode (`center_mode`=0), so the code runs from 0 to -250 or -750.
- R3: In center mode (`center_mode`=1), top = span/2, so the code runs from +125 to -125 (narrow) or from +375 to -375 (wide).
- R4: While `spread_en_n` is sampled high, `offset_code` is 0 from the next cycle on. Once it is sampled low, the following cycle shows phase 0 and the phase then advances by one per cycle.
- R5: `restart_in` passes through two synchronizing flops. A rising edge sets the phase to 0 in the third cycle after the input rises. Holding the input high does not restart the sweep again.
- R6: The profile is 1024 cycles long and begins at the maximum-frequency end (t = 0). Phase 1023 is followed by phase 0.
- R7: A change of `wide_sel` or `center_mode` is applied only when a new period begins: at a wrap, at a restart, or when the sweep is switched on. The sweep never changes shape in mid-period.
- R8: `solo_oe` follows `en_a` and `grp5_oe` follows `en_b`. Both low turns every output off, and both high turns both groups on. A disabled output's control is 0.
- R9: `ref_active` is always 1, whatever the state of `spread_en_n`.
- R10: While the synchronous reset `rst` is high, `offset_code` is 0 and the phase is held at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| spread_en_n | input | 1 | Sweep enable, active low |
| wide_sel | input | 1 | Span select: 0 = 1.25%, 1 = 3.75% |
| center_mode | input | 1 | 0 = down spread, 1 = center spread |
| restart_in | input | 1 | Asynchronous profile restart, rising edge |
| en_a | input | 1 | Enable pin for the sixth output |
| en_b | input | 1 | Enable pin for the five-output group |
| offset_code | output | 12 | Signed frequency offset, 0.005% per code |
| grp5_oe | output | 1 | Gate control for the five-output group |
| solo_oe | output | 1 | Gate control for the sixth output |
| ref_active | output | 1 | Unmodulated reference copy is active |

## Verification
The hardest case to reach from the ports is a span or mode change that arrives mid-sweep and must stay invisible until the period wraps. The bench changes both straps at phase 100. It then runs the sweep to phase 600 and checks that the old shape still holds. Next it crosses the 1023-to-0 wrap and checks that the new top value appears exactly at phase 0. Restart timing through the synchronizer is pinned by sampling the cycle just before the reset of the phase and the cycle of it, with the input then held high.

// File: rtl/ssc_pkg.sv
package ssc_pkg;

  // Offset in half-units for folded triangle position t in 0..t_max.
  function automatic int profile_offset(int t, int t_max, int span, bit center);
    int top;
    top = center ? (span / 2) : 0;
    return top - ((span * t) / t_max);
  endfunction

endpackage

// File: rtl/ssc_restart_sync.sv
module ssc_restart_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise_pulse
);
  logic [STAGES-1:0] chain;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= 1'b0;
    else     chain[0] <= async_in;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[i] <= 1'b0;
      else     chain[i] <= chain[i-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) last_q <= 1'b0;
    else     last_q <= chain[STAGES-1];
  end

  assign rise_pulse = chain[STAGES-1] & ~last_q;
endmodule

// File: rtl/ssc_phase_gen.sv
module ssc_phase_gen #(
  parameter int PHASE_W = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               spread_en_n,
  input  logic               wide_sel,
  input  logic               center_mode,
  input  logic               restart_pulse,
  output logic               run_q,
  output logic [PHASE_W-1:0] phase_q,
  output logic               cfg_wide,
  output logic               cfg_center,
  output logic               wrap
);
  localparam logic [PHASE_W-1:0] PHASE_LAST = '1;

  logic load_cfg;

  assign wrap     = run_q && (phase_q == PHASE_LAST);
  assign load_cfg = restart_pulse || !run_q || wrap;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q      <= 1'b0;
      phase_q    <= '0;
      cfg_wide   <= wide_sel;
      cfg_center <= center_mode;
    end else begin
      run_q <= ~spread_en_n;
      if (restart_pulse || !run_q) phase_q <= '0;
      else                         phase_q <= phase_q + 1'b1;
      if (load_cfg) begin
        cfg_wide   <= wide_sel;
        cfg_center <= center_mode;
      end
    end
  end
endmodule

// File: rtl/ssc_offset_map.sv
module ssc_offset_map
  import ssc_pkg::*;
#(
  parameter int PHASE_W     = 10,
  parameter int OFS_W       = 12,
  parameter int SPAN_NARROW = 250,
  parameter int SPAN_WIDE   = 750
) (
  input  logic                    run,
  input  logic [PHASE_W-1:0]      phase,
  input  logic                    wide,
  input  logic                    center,
  output logic signed [OFS_W-1:0] offset
);
  localparam int HALF_W = PHASE_W - 1;
  localparam int T_MAX  = (1 << HALF_W) - 1;

  logic [HALF_W-1:0] fold;
  int                value;

  assign fold = phase[PHASE_W-1] ? ~phase[HALF_W-1:0] : phase[HALF_W-1:0];

  always_comb begin
    value  = profile_offset(int'(fold), T_MAX, wide ? SPAN_WIDE : SPAN_NARROW, center);
    offset = run ? OFS_W'(value) : '0;
  end
endmodule

// File: rtl/ssc_oe_decode.sv
module ssc_oe_decode (
  input  logic en_a,
  input  logic en_b,
  output logic grp5_oe,
  output logic solo_oe
);
  always_comb begin
    unique case ({en_a, en_b})
      2'b00:   begin grp5_oe = 1'b0; solo_oe = 1'b0; end
      2'b01:   begin grp5_oe = 1'b1; solo_oe = 1'b0; end
      2'b10:   begin grp5_oe = 1'b0; solo_oe = 1'b1; end
      default: begin grp5_oe = 1'b1; solo_oe = 1'b1; end
    endcase
  end
endmodule

// File: rtl/ssc_profile_ctrl.sv
module ssc_profile_ctrl #(
  parameter int PHASE_W     = 10,
  parameter int OFS_W       = 12,
  parameter int SPAN_NARROW = 250,
  parameter int SPAN_WIDE   = 750,
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    spread_en_n,
  input  logic                    wide_sel,
  input  logic                    center_mode,
  input  logic                    restart_in,
  input  logic                    en_a,
  input  logic                    en_b,
  output logic signed [OFS_W-1:0] offset_code,
  output logic                    grp5_oe,
  output logic                    solo_oe,
  output logic                    ref_active
);
  // Named internal events, observed by the bound checker.
  logic               restart_pulse;
  logic               run_q;
  logic [PHASE_W-1:0] phase_q;
  logic               cfg_wide;
  logic               cfg_center;
  logic               wrap;

  ssc_restart_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst        (rst),
    .async_in   (restart_in),
    .rise_pulse (restart_pulse)
  );

  ssc_phase_gen #(.PHASE_W(PHASE_W)) u_phase (
    .clk           (clk),
    .rst           (rst),
    .spread_en_n   (spread_en_n),
    .wide_sel      (wide_sel),
    .center_mode   (center_mode),
    .restart_pulse (restart_pulse),
    .run_q         (run_q),
    .phase_q       (phase_q),
    .cfg_wide      (cfg_wide),
    .cfg_center    (cfg_center),
    .wrap          (wrap)
  );

  ssc_offset_map #(
    .PHASE_W     (PHASE_W),
    .OFS_W       (OFS_W),
    .SPAN_NARROW (SPAN_NARROW),
    .SPAN_WIDE   (SPAN_WIDE)
  ) u_map (
    .run    (run_q),
    .phase  (phase_q),
    .wide   (cfg_wide),
    .center (cfg_center),
    .offset (offset_code)
  );

  ssc_oe_decode u_oe (
    .en_a    (en_a),
    .en_b    (en_b),
    .grp5_oe (grp5_oe),
    .solo_oe (solo_oe)
  );

  assign ref_active = 1'b1;
endmodule

// File: rtl/ssc_profile_chk.sv
module ssc_profile_chk #(
  parameter int PHASE_W     = 10,
  parameter int OFS_W       = 12,
  parameter int SPAN_NARROW = 250,
  parameter int SPAN_WIDE   = 750
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    spread_en_n,
  input logic                    en_a,
  input logic                    en_b,
  input logic signed [OFS_W-1:0] offset_code,
  input logic                    grp5_oe,
  input logic                    solo_oe,
  input logic                    ref_active,
  input logic                    restart_pulse,
  input logic                    run_q,
  input logic [PHASE_W-1:0]      phase_q,
  input logic                    cfg_wide,
  input logic                    cfg_center,
  input logic                    wrap
);
  // R2: down mode never goes above nominal nor below the span
  a_r2_down_range: assert property (@(posedge clk) disable iff (rst)
    (run_q && !cfg_center) |->
      (offset_code <= 0 && offset_code >= -(cfg_wide ? SPAN_WIDE : SPAN_NARROW)));

  // R3: center mode stays within plus/minus half the span
  a_r3_center_range: assert property (@(posedge clk) disable iff (rst)
    (run_q && cfg_center) |->
      (offset_code <= (cfg_wide ? SPAN_WIDE : SPAN_NARROW) / 2 &&
       offset_code >= -((cfg_wide ? SPAN_WIDE : SPAN_NARROW) / 2)));

  // R4: sweep off gives a zero code in the next cycle
  a_r4_zero_when_off: assert property (@(posedge clk) disable iff (rst)
    ($past(spread_en_n) && !$past(rst)) |-> (offset_code == 0));

  // R5: a detected restart edge puts the phase at 0
  a_r5_restart_zero: assert property (@(posedge clk) disable iff (rst)
    restart_pulse |=> (phase_q == '0));

  // R6: phase advances by one per cycle while running
  a_r6_phase_step: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(run_q) && run_q && !$past(restart_pulse)) |->
      (phase_q == PHASE_W'($past(phase_q) + 1'b1)));

  // R6: a wrap is followed by phase 0
  a_r6_wrap_zero: assert property (@(posedge clk) disable iff (rst)
    wrap |=> (phase_q == '0));

  // R7: shape latched for the whole period
  a_r7_cfg_hold: assert property (@(posedge clk) disable iff (rst)
    (phase_q != '0) |-> ($stable(cfg_wide) && $stable(cfg_center)));

  // R8: an enabled gate implies its pin is high
  a_r8_oe_decode: assert property (@(posedge clk) disable iff (rst)
    (grp5_oe |-> en_b) and (solo_oe |-> en_a));

  // R9: reference copy always reported active
  a_r9_ref_on: assert property (@(posedge clk) disable iff (rst)
    ref_active == 1'b1);

  // R10: reset leaves phase at 0
  a_r10_reset_phase: assert property (@(posedge clk)
    $past(rst) |-> (phase_q == '0));
endmodule

bind ssc_profile_ctrl ssc_profile_chk #(
  .PHASE_W     (PHASE_W),
  .OFS_W       (OFS_W),
  .SPAN_NARROW (SPAN_NARROW),
  .SPAN_WIDE   (SPAN_WIDE)
) u_chk (
  .clk           (clk),
  .rst           (rst),
  .spread_en_n   (spread_en_n),
  .en_a          (en_a),
  .en_b          (en_b),
  .offset_code   (offset_code),
  .grp5_oe       (grp5_oe),
  .solo_oe       (solo_oe),
  .ref_active    (ref_active),
  .restart_pulse (restart_pulse),
  .run_q         (run_q),
  .phase_q       (phase_q),
  .cfg_wide      (cfg_wide),
  .cfg_center    (cfg_center),
  .wrap          (wrap)
);

// File: tb/ssc_profile_ctrl_tb.sv
`timescale 1ns/1ps
module ssc_profile_ctrl_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic spread_en_n = 1'b0;
  logic wide_sel = 1'b0;
  logic center_mode = 1'b1;
  logic restart_in = 1'b0;
  logic en_a = 1'b0;
  logic en_b = 1'b0;
  logic signed [11:0] offset_code;
  logic grp5_oe, solo_oe, ref_active;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ssc_profile_ctrl u_dut (
    .clk(clk), .rst(rst), .spread_en_n(spread_en_n), .wide_sel(wide_sel),
    .center_mode(center_mode), .restart_in(restart_in), .en_a(en_a), .en_b(en_b),
    .offset_code(offset_code), .grp5_oe(grp5_oe), .solo_oe(solo_oe),
    .ref_active(ref_active)
  );

  // Stimulus table: [11]=wide, [10]=center, [9:0]=phase at which to sample
  localparam logic [11:0] VEC [8] = '{
    {1'b0, 1'b0, 10'd0},   {1'b0, 1'b0, 10'd511},
    {1'b1, 1'b0, 10'd512}, {1'b1, 1'b0, 10'd300},
    {1'b0, 1'b1, 10'd0},   {1'b0, 1'b1, 10'd700},
    {1'b1, 1'b1, 10'd256}, {1'b1, 1'b1, 10'd1023}
  };

  // Expected code from the requirement formula, written independently
  function automatic int expect_code(int p, bit w, bit c);
    int span, t, prod;
    span = w ? 750 : 250;
    t    = (p < 512) ? p : (1023 - p);
    prod = span * t;
    return (c ? span / 2 : 0) - ((prod - (prod % 511)) / 511);
  endfunction

  task automatic tick(int n);
    repeat (n) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic check(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #1500000;
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    // R10: reset state
    tick(3);
    check("R10 reset offset", int'(offset_code), 0);
    check("R9 ref active in reset", int'(ref_active), 1);
    rst = 1'b0;
    tick(1);
    check("R10/R6 first cycle after reset at top", int'(offset_code), 125);

    // R8: enable decode, all four combinations
    for (int k = 0; k < 4; k++) begin
      en_a = k[1];
      en_b = k[0];
      #1;
      check("R8 group of five", int'(grp5_oe), int'(k[0]));
      check("R8 sixth output", int'(solo_oe), int'(k[1]));
    end

    // R1/R2/R3: table walk
    for (int i = 0; i < 8; i++) begin
      spread_en_n = 1'b1;
      wide_sel    = VEC[i][11];
      center_mode = VEC[i][10];
      tick(2);
      spread_en_n = 1'b0;
      tick(1 + int'(VEC[i][9:0]));
      check(VEC[i][10] ? "R3 center table" : "R2 down table", int'(offset_code),
            expect_code(int'(VEC[i][9:0]), VEC[i][11], VEC[i][10]));
    end

    // R4: switching the sweep off gives zero, R9 still active
    tick(5);
    spread_en_n = 1'b1;
    tick(1);
    check("R4 zero after disable", int'(offset_code), 0);
    tick(3);
    check("R4 stays zero", int'(offset_code), 0);
    check("R9 ref active with sweep off", int'(ref_active), 1);

    // R7: mid-period strap change waits for the wrap
    wide_sel = 1'b0;
    center_mode = 1'b0;
    spread_en_n = 1'b0;
    tick(1);
    tick(100);
    wide_sel = 1'b1;
    center_mode = 1'b1;
    tick(1);
    check("R7 old shape at phase 101", int'(offset_code), expect_code(101, 1'b0, 1'b0));
    tick(499);
    check("R7 old shape at phase 600", int'(offset_code), expect_code(600, 1'b0, 1'b0));
    tick(424);
    check("R7 new shape at phase 0", int'(offset_code), 375);
    tick(1);
    check("R6 phase 1 after wrap", int'(offset_code), expect_code(1, 1'b1, 1'b1));

    // R6: full period returns to the top
    tick(1023);
    check("R6 period of 1024", int'(offset_code), 375);

    // R5: restart through the synchronizer
    tick(200);
    restart_in = 1'b1;
    tick(2);
    check("R5 no restart yet", int'(offset_code), expect_code(202, 1'b1, 1'b1));
    tick(1);
    check("R5 restart to phase 0", int'(offset_code), 375);
    tick(10);
    check("R5 held level no second restart", int'(offset_code), expect_code(10, 1'b1, 1'b1));
    restart_in = 1'b0;
    tick(5);
    check("R5 falling edge ignored", int'(offset_code), expect_code(15, 1'b1, 1'b1));

    // R10: reset mid-sweep
    rst = 1'b1;
    tick(1);
    check("R10 reset mid-sweep", int'(offset_code), 0);
    rst = 1'b0;
    tick(1);
    check("R10 restart at phase 0", int'(offset_code), 375);

    done = 1'b1;
    summary();
  end
endmodule